// File: doc/BRIEF.md
# Supervisory reset and watchdog sequencer

This block is the digital core of a microprocessor supervisor. An external comparator delivers a digitised supply-valid flag that is already synchronous to the system clock. The block combines that flag with an active-low manual-reset request and a watchdog kick line, and drives a pair of complementary reset outputs, one active high and one active low, both taken straight from flip-flops.

Reset is held while the supply is invalid or the manual request is low. Every reset, whatever caused it, is stretched by a recovery period that starts only when all causes are gone. While the reset is released the watchdog counts clock cycles. Each transition of the kick line, rising or falling, restarts the count. If the count runs out, the watchdog forces a reset. The watchdog counter stays at zero for the whole of a reset, so a kick line stuck at one level produces a train of reset pulses. A watchdog-enable input stands in for a kick line left floating: while it is low the watchdog never fires. Both periods are parameters in clock cycles; the defaults assume a 50 MHz clock, 200 ms of recovery and a 1.6 s timeout.

Top module: `rsup_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it falls, `reset_o` is 1 and `reset_n_o` is 0. After `rst` falls, with no cause active, the block needs REC_CYCLES cause-free rising edges to release.
- R2: If `supply_ok_i` is 0 at a rising edge, `reset_o` is 1 after that edge.
- R3: `mrst_n_i` passes through a two-flop synchroniser. A low level sampled at edge n asserts `reset_o` after edge n+2, even if the low lasts only one cycle.
- R4: `reset_o` falls at the REC_CYCLES-th consecutive rising edge at which no cause is present. A cause that appears during recovery restarts the count from zero.
- R5: A loss of supply during recovery clears the recovery count. Counting starts again only after the supply is valid again.
- R6: With `wdt_en_i` high and reset released, if the synchronised kick line has no transition for WDT_CYCLES consecutive edges, `reset_o` asserts at the WDT_CYCLES-th of those edges.
- R7: Both a 0-to-1 and a 1-to-0 transition of `kick_i` restart the watchdog count. The kick line passes through a two-flop synchroniser, so a transition sampled at edge n takes effect at edge n+2.
- R8: The watchdog count stays at zero while `reset_o` is 1. With `kick_i` constant, rising edges of `reset_o` recur every WDT_CYCLES + REC_CYCLES cycles.
- R9: While `wdt_en_i` is 0 the watchdog count stays at zero and never causes a reset.
- R10: `reset_n_o` is the complement of `reset_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_ok_i | input | 1 | Digitised supply-valid flag, synchronous to clk |
| mrst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| wdt_en_i | input | 1 | Watchdog enable (0 models a floating kick line) |
| kick_i | input | 1 | Watchdog kick line, asynchronous |
| reset_o | output | 1 | Registered reset, active high |
| reset_n_o | output | 1 | Registered reset, active low |

## Verification
Two of the block's functions can land in the same cycle: a watchdog expiry and the kick transition that should have prevented it. The bench provokes this case as follows. A stuck kick line produces repeated resets. After each release the bench toggles the kick line at a delay swept across the cycles just before, on and after the timeout edge, so the synchronised transition falls on each side of the expiry. A cycle-accurate reference model written with integers decides whether a reset must follow. The outputs are compared with the model on every clock, and the spacing of the pulses caused by a stuck kick line is measured.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  // Counter width that can hold the value n.
  function automatic int cnt_width(input int n);
    int w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Reset causes gathered in one place.
  typedef struct packed {
    logic supply_lost;
    logic manual;
    logic wdog;
  } cause_t;

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog #(
  parameter int TIMEOUT = 80_000_000,
  parameter int CW      = rsup_pkg::cnt_width(TIMEOUT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          kick_s_i,
  input  logic          hold_i,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          kick_d;
  logic          kick_edge;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) kick_d <= 1'b0;
    else     kick_d <= kick_s_i;
  end

  assign kick_edge = kick_s_i ^ kick_d;
  assign expire_o  = en_i && !hold_i && !kick_edge && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (hold_i || !en_i || kick_edge || expire_o)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rsup_recovery.sv
module rsup_recovery #(
  parameter int PERIOD = 10_000_000,
  parameter int CW     = rsup_pkg::cnt_width(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cause_i,
  output logic          act_o,
  output logic          act_n_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic          act_q;
  logic          act_n_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b1;
      act_n_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cause_i) begin
      act_q   <= 1'b1;
      act_n_q <= 1'b0;
      cnt_q   <= '0;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_q   <= 1'b0;
        act_n_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign act_o   = act_q;
  assign act_n_o = act_n_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/rsup_seq.sv
module rsup_seq #(
  parameter int REC_CYCLES  = 10_000_000,
  parameter int WDT_CYCLES  = 80_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic mrst_n_i,
  input  logic wdt_en_i,
  input  logic kick_i,
  output logic reset_o,
  output logic reset_n_o
);

  import rsup_pkg::*;

  localparam int REC_W = cnt_width(REC_CYCLES);
  localparam int WDT_W = cnt_width(WDT_CYCLES);

  logic             mrst_n_s;
  logic             kick_s;
  logic             wdt_expire;
  logic [REC_W-1:0] rec_cnt;
  logic [WDT_W-1:0] wdt_cnt;
  cause_t           cause;
  logic             any_cause;
  logic             act;
  logic             act_n;

  rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mrst (
    .clk (clk), .rst (rst), .d_i (mrst_n_i), .q_o (mrst_n_s)
  );

  rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_kick (
    .clk (clk), .rst (rst), .d_i (kick_i), .q_o (kick_s)
  );

  rsup_wdog #(.TIMEOUT(WDT_CYCLES), .CW(WDT_W)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .en_i     (wdt_en_i),
    .kick_s_i (kick_s),
    .hold_i   (act),
    .expire_o (wdt_expire),
    .cnt_o    (wdt_cnt)
  );

  always_comb begin
    cause.supply_lost = !supply_ok_i;
    cause.manual      = !mrst_n_s;
    cause.wdog        = wdt_expire;
  end

  assign any_cause = |cause;

  rsup_recovery #(.PERIOD(REC_CYCLES), .CW(REC_W)) u_rec (
    .clk     (clk),
    .rst     (rst),
    .cause_i (any_cause),
    .act_o   (act),
    .act_n_o (act_n),
    .cnt_o   (rec_cnt)
  );

  assign reset_o   = act;
  assign reset_n_o = act_n;

endmodule

// File: rtl/rsup_seq_chk.sv
module rsup_seq_chk #(
  parameter int REC_CYCLES = 10_000_000,
  parameter int WDT_CYCLES = 80_000_000,
  parameter int REC_W      = rsup_pkg::cnt_width(REC_CYCLES),
  parameter int WDT_W      = rsup_pkg::cnt_width(WDT_CYCLES)
) (
  input logic             clk,
  input logic             rst,
  input logic             supply_ok_i,
  input logic             wdt_en_i,
  input logic             reset_o,
  input logic             reset_n_o,
  input logic [REC_W-1:0] rec_cnt,
  input logic [WDT_W-1:0] wdt_cnt
);

  p_complement_r10: assert property (@(posedge clk) disable iff (rst)
    reset_n_o == !reset_o);

  p_supply_assert_r2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> reset_o);

  p_release_after_period_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_o) |-> $past(rec_cnt) == REC_W'(REC_CYCLES - 1));

  p_wdt_cleared_in_reset_r8: assert property (@(posedge clk) disable iff (rst)
    reset_o |=> wdt_cnt == '0);

  p_wdt_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    !wdt_en_i |=> wdt_cnt == '0);

  p_wdt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    wdt_cnt < WDT_W'(WDT_CYCLES));

endmodule

bind rsup_seq rsup_seq_chk #(
  .REC_CYCLES (REC_CYCLES),
  .WDT_CYCLES (WDT_CYCLES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .supply_ok_i (supply_ok_i),
  .wdt_en_i    (wdt_en_i),
  .reset_o     (reset_o),
  .reset_n_o   (reset_n_o),
  .rec_cnt     (rec_cnt),
  .wdt_cnt     (wdt_cnt)
);

// File: tb/sim_rsup_seq.sv
module sim_rsup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int REC = 12;
  localparam int WDT = 20;
  localparam int LIMIT = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b1;
  logic mrst_n = 1'b1;
  logic wdt_en = 1'b1;
  logic kick = 1'b0;
  logic reset_o, reset_n_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  int m_rst = 1, m_rem = REC, m_wcnt = 0;
  int ms1 = 1, ms2 = 1, ks1 = 0, ks2 = 0, kd = 0;

  // pulse spacing measurement
  int rises = 0, last_rise = 0, prev_rise = 0;
  logic prev_obs = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsup_seq #(.REC_CYCLES(REC), .WDT_CYCLES(WDT)) u0 (
    .clk (clk), .rst (rst), .supply_ok_i (supply_ok), .mrst_n_i (mrst_n),
    .wdt_en_i (wdt_en), .kick_i (kick), .reset_o (reset_o), .reset_n_o (reset_n_o)
  );

  always @(posedge clk) begin
    int edge_seen, expire, cause;
    cyc++;
    if (rst) begin
      m_rst = 1; m_rem = REC; m_wcnt = 0;
      ms1 = 1; ms2 = 1; ks1 = 0; ks2 = 0; kd = 0;
    end else begin
      edge_seen = (ks2 != kd);
      expire = (wdt_en && m_rst == 0 && !edge_seen && m_wcnt == WDT - 1);
      cause = (!supply_ok || ms2 == 0 || expire);
      if (m_rst != 0 || !wdt_en || edge_seen || expire) m_wcnt = 0;
      else m_wcnt++;
      if (cause) begin
        m_rst = 1; m_rem = REC;
      end else if (m_rst != 0) begin
        m_rem--;
        if (m_rem == 0) m_rst = 0;
      end
      kd = ks2; ks2 = ks1; ks1 = kick;
      ms2 = ms1; ms1 = mrst_n;
    end
  end

  always @(negedge clk) begin
    if (!done && cyc > 0) begin
      checks++;
      if (reset_o !== m_rst[0]) begin
        errors++;
        $display("FAIL %s cycle %0d: reset_o=%0b expected %0b", tag, cyc, reset_o, m_rst[0]);
      end
      checks++;
      if (reset_n_o !== ~reset_o) begin
        errors++;
        $display("FAIL R10 cycle %0d: reset_n_o=%0b expected %0b", cyc, reset_n_o, ~reset_o);
      end
      if (reset_o && !prev_obs) begin
        rises++; prev_rise = last_rise; last_rise = cyc;
      end
      prev_obs = reset_o;
    end
  end

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_toggle(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      if (i % period == 0) kick = ~kick;
      @(negedge clk);
    end
  endtask

  task automatic check_val(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got %0d cycles expected fewer", LIMIT);
    finish_sim();
  end

  initial begin
    int hi_cycles;
    tag = "R1";
    step(4);
    check_val("R1 reset_o during rst", reset_o, 1);
    check_val("R1 reset_n_o during rst", reset_n_o, 0);
    rst = 1'b0;
    step(1);
    check_val("R1 reset_o after rst", reset_o, 1);
    run_toggle(REC + 10, 5);
    check_val("R1 released after recovery", reset_o, 0);

    tag = "R7";
    run_toggle(80, 7);
    check_val("R7 kicks keep reset off", reset_o, 0);

    tag = "R2";
    supply_ok = 1'b0;
    run_toggle(3, 5);
    check_val("R2 supply loss asserts", reset_o, 1);
    supply_ok = 1'b1;
    tag = "R5";
    run_toggle(5, 5);
    supply_ok = 1'b0;
    run_toggle(1, 5);
    supply_ok = 1'b1;
    run_toggle(REC - 2, 5);
    check_val("R5 recovery restarted", reset_o, 1);
    run_toggle(10, 5);
    check_val("R5 released", reset_o, 0);

    tag = "R3";
    mrst_n = 1'b0;
    run_toggle(4, 5);
    check_val("R3 manual asserts", reset_o, 1);
    mrst_n = 1'b1;
    tag = "R4";
    run_toggle(6, 5);
    mrst_n = 1'b0;
    run_toggle(1, 5);
    mrst_n = 1'b1;
    run_toggle(REC + 8, 5);
    check_val("R4 released after retrigger", reset_o, 0);

    tag = "R6";
    step(3 * (WDT + REC) + 5);
    tag = "R8";
    check_val("R8 pulse spacing", last_rise - prev_rise, WDT + REC);

    tag = "R7";
    for (int d = WDT - 5; d <= WDT + 1; d++) begin
      while (reset_o !== 1'b1) step(1);
      while (reset_o !== 1'b0) step(1);
      step(d);
      kick = ~kick;
      step(4);
    end

    tag = "R9";
    wdt_en = 1'b0;
    step(REC + WDT + 4);
    hi_cycles = 0;
    for (int i = 0; i < 3 * WDT; i++) begin
      step(1);
      if (reset_o) hi_cycles++;
    end
    check_val("R9 disabled watchdog never fires", hi_cycles, 0);

    finish_sim();
  end

endmodule